// File: doc/BRIEF.md
# Multi-lane symbol striper

This block takes a byte-wide stream of framed packet symbols and spreads it across the lanes of an x1, x4 or x8 link. Each input symbol carries a control (K) flag and may be marked as the first or last symbol of a packet. Separately, it may be marked as part of an ordered set. The block collects packet symbols into a lane group. It emits the whole group on one strobe, with one symbol and one K flag per lane.

Framing characters land on lanes that a receiver can check. A packet that follows idle time opens on lane 0. A packet that ends part-way through a group leaves the remaining lanes to be padded, unless a new packet is offered at once. In that case the new packet continues on the next lane, which is a multiple of 4. Logical idle and ordered-set symbols never share a group with packet data. Each such symbol is copied to every active lane in the same group.

The lane count is chosen by `lane_mode`. It is expected to change only while reset is held. Packet lengths are assumed to be whole dwords, so end characters fall on lanes 3, 7 and so on.

Top module: `lane_striper`

## Requirements
- R1: With `lane_mode`=0 (x1), each accepted symbol appears on lane 0 with its K flag, and `out_valid` is high, on the clock edge after it is accepted.
- R2: With `lane_mode`=1 (x4) or 2 (x8), consecutive packet symbols fill lanes 0,1,2,... in order. The full group is emitted on the edge that accepts the symbol for the last active lane.
- R3: The first symbol accepted after idle or after a padded group is placed on lane 0.
- R4: If a packet ends on lane 3 of an x8 group and a start symbol (`in_sop`) is valid in the next cycle, that symbol is accepted and placed on lane 4 of the same group.
- R5: For a packet whose length is a multiple of 4 symbols, the end symbol is placed on lane 3 or lane 7.
- R6: If a packet ends before the last active lane and no start symbol is offered in the next cycle, the group is emitted with PAD (F7h, K=1) on every lane after the end symbol. This happens on the edge that closes that cycle.
- R7: When no input is valid, no packet is open and the group is empty, the block emits a group with data 00h and K=0 on every active lane on each edge.
- R8: A symbol accepted with `in_os` high is emitted on the next edge, with its value and K flag copied to every active lane.
- R9: While a padded group is pending, `in_ready` is low unless a valid, non-ordered-set start symbol is offered. An ordered-set symbol offered then is accepted only in the following cycle.
- R10: Lanes at or above the active lane count (lanes 1-7 in x1, lanes 4-7 in x4) always output 00h with K=0.
- R11: While `rst` is high, `out_valid`, `out_sym` and `out_k` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_mode | input | 2 | 0 = x1, 1 = x4, 2 or 3 = x8 |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Input symbol accepted this cycle when high with `in_valid` |
| in_sym | input | 8 | Symbol byte |
| in_k | input | 1 | Symbol is a control character |
| in_sop | input | 1 | First symbol of a packet |
| in_eop | input | 1 | Last symbol of a packet |
| in_os | input | 1 | Symbol belongs to an ordered set |
| out_valid | output | 1 | A lane group is presented this cycle |
| out_sym | output | LANES*8 | Lane i symbol in bits [8i+7:8i] |
| out_k | output | LANES | Lane i K flag in bit i |

## Verification
A wrong lane pointer shows in the first group emitted after the fault. Symbols appear shifted across lanes, or a group strobes one symbol early or late. A pending-pad flag stuck in the wrong state shows within one cycle: `in_ready` drops when it should not, a back-to-back start is refused, or PAD appears where packet data should be. Because idle groups are emitted on every empty cycle, a stale open-packet flag shows as missing idle strobes as soon as input goes quiet.

// File: rtl/lane_striper.sv
module lane_striper #(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         lane_mode,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_sym,
  input  logic               in_k,
  input  logic               in_sop,
  input  logic               in_eop,
  input  logic               in_os,
  output logic               out_valid,
  output logic [LANES*8-1:0] out_sym,
  output logic [LANES-1:0]   out_k
);
  localparam int PW = $clog2(LANES);
  localparam logic [7:0] PAD = 8'hF7;

  logic [7:0]       held_sym [LANES];
  logic [LANES-1:0] held_k;
  logic [PW-1:0]    pos;
  logic             in_pkt, pend;
  logic [PW:0]      act;
  logic             acc, last, e_flush, e_idle, e_os, e_last, emit;
  logic [LANES*8-1:0] grp_sym;
  logic [LANES-1:0]   grp_k;

  assign act = (lane_mode == 2'd0) ? (PW+1)'(1) :
               (lane_mode == 2'd1) ? (PW+1)'(4) : (PW+1)'(LANES);
  assign last = ({1'b0, pos} == act - 1'b1);

  assign in_ready = pend ? (in_valid & in_sop & ~in_os) : ~(in_os & in_pkt);
  assign acc      = in_valid & in_ready;

  assign e_flush = pend & ~(in_valid & in_sop & ~in_os);
  assign e_idle  = ~in_valid & ~in_pkt & ~pend & (pos == '0);
  assign e_os    = acc & in_os;
  assign e_last  = acc & ~in_os & last;
  assign emit    = e_flush | e_idle | e_os | e_last;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (i >= int'(act)) begin
        grp_sym[8*i +: 8] = '0;
        grp_k[i]          = 1'b0;
      end else if (e_flush) begin
        grp_sym[8*i +: 8] = (i < int'(pos)) ? held_sym[i] : PAD;
        grp_k[i]          = (i < int'(pos)) ? held_k[i] : 1'b1;
      end else if (e_idle) begin
        grp_sym[8*i +: 8] = '0;
        grp_k[i]          = 1'b0;
      end else if (in_os) begin
        grp_sym[8*i +: 8] = in_sym;
        grp_k[i]          = in_k;
      end else begin
        grp_sym[8*i +: 8] = (i == int'(pos)) ? in_sym : held_sym[i];
        grp_k[i]          = (i == int'(pos)) ? in_k : held_k[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= '0;
      in_pkt    <= 1'b0;
      pend      <= 1'b0;
      out_valid <= 1'b0;
      out_sym   <= '0;
      out_k     <= '0;
      held_k    <= '0;
      for (int i = 0; i < LANES; i++) held_sym[i] <= '0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        out_sym <= grp_sym;
        out_k   <= grp_k;
      end
      if (e_flush) begin
        pos    <= '0;
        pend   <= 1'b0;
        in_pkt <= 1'b0;
      end else if (acc && !in_os) begin
        held_sym[pos] <= in_sym;
        held_k[pos]   <= in_k;
        in_pkt        <= ~in_eop;
        if (last) begin
          pos  <= '0;
          pend <= 1'b0;
        end else begin
          pos  <= pos + 1'b1;
          pend <= in_eop;
        end
      end
    end
  end
endmodule

module lane_striper_chk #(
  parameter int LANES = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         lane_mode,
  input logic               in_valid,
  input logic               in_ready,
  input logic [7:0]         in_sym,
  input logic               in_k,
  input logic               in_sop,
  input logic               in_os,
  input logic               out_valid,
  input logic [LANES*8-1:0] out_sym,
  input logic [LANES-1:0]   out_k,
  input logic               pend,
  input logic               in_pkt,
  input logic               pos_zero
);
  // R1
  x1_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_mode == 2'd0 && in_valid && in_ready) |=>
      (out_valid && out_sym[7:0] == $past(in_sym) && out_k[0] == $past(in_k)));

  // R8
  os_bcast_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_mode != 2'd0 && in_valid && in_ready && in_os) |=>
      (out_valid && out_sym[15:8] == $past(in_sym) && out_sym[31:24] == $past(in_sym)
       && out_k[3] == $past(in_k)));

  // R10
  unused_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_mode == 2'd0 && $stable(lane_mode)) |->
      (out_sym[LANES*8-1:8] == '0 && out_k[LANES-1:1] == '0));

  // R6
  pad_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (lane_mode >= 2'd2 && pend && !(in_valid && in_sop && !in_os)) |=>
      (out_valid && out_k[LANES-1] && out_sym[LANES*8-1 -: 8] == 8'hF7));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !in_pkt && !pend && pos_zero) |=>
      (out_valid && out_sym == '0 && out_k == '0));
endmodule

bind lane_striper lane_striper_chk #(.LANES(LANES)) chk (
  .clk(clk), .rst(rst), .lane_mode(lane_mode), .in_valid(in_valid),
  .in_ready(in_ready), .in_sym(in_sym), .in_k(in_k), .in_sop(in_sop),
  .in_os(in_os), .out_valid(out_valid), .out_sym(out_sym), .out_k(out_k),
  .pend(pend), .in_pkt(in_pkt), .pos_zero(pos == '0)
);

// File: tb/lane_striper_test.sv
module lane_striper_test;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] lane_mode;
  logic in_valid, in_ready, in_k, in_sop, in_eop, in_os;
  logic [7:0] in_sym;
  logic out_valid;
  logic [63:0] out_sym;
  logic [7:0] out_k;
  int checks = 0, fails = 0;
  logic got_rdy;

  always #4 clk = ~clk;

  lane_striper #(.LANES(8)) uut (
    .clk(clk), .rst(rst), .lane_mode(lane_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_sym(in_sym), .in_k(in_k), .in_sop(in_sop),
    .in_eop(in_eop), .in_os(in_os), .out_valid(out_valid),
    .out_sym(out_sym), .out_k(out_k)
  );

  // {valid, os, sop, eop, k, sym, exp_ready, exp_valid, exp_k, exp_sym}  x8 mode
  localparam int NV = 23;
  localparam logic [86:0] VEC [NV] = '{
    {5'b00000, 8'h00, 1'b1, 1'b1, 8'h00, 64'h0},
    {5'b10101, 8'hFB, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h01, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h02, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h03, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h04, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h05, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h06, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10011, 8'hFD, 1'b1, 1'b1, 8'h81, 64'hFD060504030201FB},
    {5'b10101, 8'h5C, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h11, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h12, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10011, 8'hFD, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10101, 8'hFB, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h21, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h22, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10011, 8'hFD, 1'b1, 1'b1, 8'h99, 64'hFD2221FBFD12115C},
    {5'b10101, 8'h5C, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h31, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10000, 8'h32, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b10011, 8'hFD, 1'b1, 1'b0, 8'h00, 64'h0},
    {5'b00000, 8'h00, 1'b0, 1'b1, 8'hF9, 64'hF7F7F7F7FD32315C},
    {5'b00000, 8'h00, 1'b1, 1'b1, 8'h00, 64'h0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    in_valid = 0; in_os = 0; in_sop = 0; in_eop = 0; in_k = 0; in_sym = 8'h00;
  endtask

  // drive at negedge, sample ready before the edge and outputs just after it
  task automatic drive(input logic v, input logic os, input logic sop, input logic eop,
                       input logic k, input logic [7:0] sym);
    @(negedge clk);
    in_valid = v; in_os = os; in_sop = sop; in_eop = eop; in_k = k; in_sym = sym;
    #1 got_rdy = in_ready;
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst = 1; lane_mode = m; idle_in();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst = 1; lane_mode = 2'd2; idle_in();
    repeat (3) @(posedge clk);
    #2;
    // R11 reset state
    check("R11 valid", {63'b0, out_valid}, 64'd0);
    check("R11 sym", out_sym, 64'd0);
    check("R11 k", {56'b0, out_k}, 64'd0);
    @(negedge clk); rst = 0;

    // table: x8 packets, back-to-back start, pad, idle (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < NV; i++) begin
      logic [86:0] e;
      e = VEC[i];
      drive(e[86], e[85], e[84], e[83], e[82], e[81:74]);
      check($sformatf("R9 R4 ready vec %0d", i), {63'b0, got_rdy}, {63'b0, e[73]});
      check($sformatf("R2 R7 valid vec %0d", i), {63'b0, out_valid}, {63'b0, e[72]});
      if (e[72]) begin
        check($sformatf("R3 R5 R6 sym vec %0d", i), out_sym, e[63:0]);
        check($sformatf("R5 R6 k vec %0d", i), {56'b0, out_k}, {56'b0, e[71:64]});
      end
    end

    // R1 R10: x1 serial order on lane 0
    do_reset(2'd0);
    drive(1, 0, 1, 0, 1, 8'hFB);
    check("R1 x1 start", {out_valid, out_k, out_sym[55:0]}, {1'b1, 8'h01, 56'hFB});
    check("R10 x1 upper", {56'b0, out_sym[63:56]}, 64'd0);
    drive(1, 0, 0, 0, 0, 8'h01);
    check("R1 x1 data", {out_valid, out_k, out_sym[55:0]}, {1'b1, 8'h00, 56'h01});
    drive(1, 0, 0, 1, 1, 8'hFD);
    check("R1 x1 end", {out_valid, out_k, out_sym[55:0]}, {1'b1, 8'h01, 56'hFD});
    drive(0, 0, 0, 0, 0, 8'h00);
    check("R7 x1 idle", {out_valid, out_k, out_sym[55:0]}, {1'b1, 8'h00, 56'h0});
    drive(1, 1, 0, 0, 1, 8'hBC);
    check("R8 x1 os", {out_valid, out_k, out_sym[55:0]}, {1'b1, 8'h01, 56'hBC});

    // R2 R5 R10: x4 group
    do_reset(2'd1);
    drive(1, 0, 1, 0, 1, 8'hFB);
    check("R2 x4 partial", {63'b0, out_valid}, 64'd0);
    drive(1, 0, 0, 0, 0, 8'h01);
    drive(1, 0, 0, 0, 0, 8'h02);
    check("R2 x4 partial2", {63'b0, out_valid}, 64'd0);
    drive(1, 0, 0, 1, 1, 8'hFD);
    check("R2 x4 valid", {63'b0, out_valid}, 64'd1);
    check("R5 R10 x4 sym", out_sym, 64'h00000000FD0201FB);
    check("R5 R10 x4 k", {56'b0, out_k}, 64'h09);

    // R6 R8 R9: ordered set held off by pending pad, then broadcast
    do_reset(2'd2);
    drive(1, 0, 1, 0, 1, 8'h5C);
    drive(1, 0, 0, 0, 0, 8'h41);
    drive(1, 0, 0, 0, 0, 8'h42);
    drive(1, 0, 0, 1, 1, 8'hFD);
    drive(1, 1, 0, 0, 1, 8'hBC);
    check("R9 os held", {63'b0, got_rdy}, 64'd0);
    check("R6 pad sym", out_sym, 64'hF7F7F7F7FD42415C);
    check("R6 pad k", {56'b0, out_k}, 64'hF9);
    drive(1, 1, 0, 0, 1, 8'hBC);
    check("R9 os taken", {63'b0, got_rdy}, 64'd1);
    check("R8 com bcast", {out_valid, out_k, out_sym[55:0]}, {1'b1, 8'hFF, 56'hBCBCBCBCBCBCBC});
    check("R8 com lane7", {56'b0, out_sym[63:56]}, 64'hBC);
    drive(1, 1, 0, 0, 1, 8'h1C);
    check("R8 skp bcast", out_sym, 64'h1C1C1C1C1C1C1C1C);
    drive(0, 0, 0, 0, 0, 8'h00);
    check("R7 idle after os", {out_valid, out_k, out_sym[55:0]}, {1'b1, 8'h00, 56'h0});
    drive(1, 0, 1, 0, 1, 8'hFB);
    drive(1, 0, 0, 0, 0, 8'h51);
    drive(1, 0, 0, 0, 0, 8'h52);
    drive(1, 0, 0, 1, 1, 8'hFD);
    drive(0, 0, 0, 0, 0, 8'h00);
    check("R3 R6 lane0 after idle", out_sym, 64'hF7F7F7F7FD5251FB);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule